// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with SPI Direction Override

This block is a six-pin bidirectional I/O port for a small microcontroller. Software sets, per pin, a direction bit and an output latch bit through a small register interface. It can also read back the live pin levels, which pass through a two-stage synchronizer first. For each pin the block drives three pad controls: an output enable, an output value and a pull-up enable. An external pad model turns these into the real pin behaviour.

When the SPI peripheral is switched on, its role decides which of four pins are forced to act as inputs, whatever their direction bits hold. The four pins are serial clock, master-in, master-out and select. A forced input still takes its pull-up from its latch bit. The block also reports when the slave is selected, which happens when the select pin is low. An active reset tri-states every pin at once, with no clock edge needed.

Top module: `gpio_spi_port`

## Requirements
- R1: After reset, the direction and latch registers read 0, and every pad output enable and every pull-up enable is 0.
- R2: A pin that is not forced by the SPI role has its output enable equal to its direction bit (1 = output, 0 = input).
- R3: The output value of every pin equals its latch bit. On a pin whose output enable is 1, the pull-up enable is 0.
- R4: On a pin whose output enable is 0, the pull-up enable equals its latch bit. With the latch bit at 0 the pin floats with no pull-up.
- R5: Address 1 reads the direction register and address 2 reads the latch register; writes to these take effect at the next clock edge. Address 3 reads 0. Writes to address 0 or address 3 change nothing.
- R6: Address 0 returns the pin levels as they were two rising clock edges earlier. A change on the pins shows one edge later as the old value and two edges later as the new value.
- R7: With the SPI enabled (spi_en=1) and spi_master=0 (slave role), pins 5 (clock), 3 (master-out) and 2 (select) have output enable 0. Pin 4 (master-in) follows its direction bit.
- R8: With the SPI enabled and spi_master=1 (master role), pin 4 has output enable 0. Pins 5, 3 and 2 follow their direction bits.
- R9: A pin forced to input by the SPI role has its pull-up enable equal to its latch bit.
- R10: Pins 1 and 0 follow their direction and latch bits in every SPI role.
- R11: spi_sel is 1 exactly when the SPI is enabled in the slave role and the synchronized level of pin 2 is 0.
- R12: While rst_n is low, every output enable is 0, and this holds without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 pins, 1 direction, 2 latch, 3 unused) |
| bus_wdata | input | 6 | Write data |
| bus_rdata | output | 6 | Read data for bus_addr |
| spi_en | input | 1 | SPI peripheral enabled |
| spi_master | input | 1 | SPI role: 1 master, 0 slave |
| pin_in | input | 6 | Sampled pad levels |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin output value |
| pad_pu | output | 6 | Per-pin pull-up enable |
| spi_sel | output | 1 | Slave selected (select pin low in slave role) |

## Verification
The hardest case to reach is the interaction between the SPI role and every direction and latch combination on the four shared pins. An override bug may show up only for one role on one pin with one latch value. The bench reaches it with a full sweep. It writes every direction value, then every latch value, and under each pair it steps through the off, slave and master roles, comparing all three pad vectors with a computed mask. The asynchronous reset case is reached by dropping rst_n halfway between clock edges with all pins driving, then checking the enables before the next edge arrives.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    ADDR_PINS  = 2'd0,
    ADDR_DIR   = 2'd1,
    ADDR_LATCH = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'd0,
    ROLE_SLAVE  = 2'd1,
    ROLE_MASTER = 2'd2
  } spi_role_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);

  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= 2'b00;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d;
    end else begin : g_rest
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pin_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] rdata
);

  reg_addr_e        sel;
  logic             dir_en;
  logic             latch_en;
  logic [WIDTH-1:0] dir_d;
  logic [WIDTH-1:0] latch_d;

  assign sel = reg_addr_e'(addr);

  always_comb begin
    dir_en   = wr && (sel == ADDR_DIR);
    latch_en = wr && (sel == ADDR_LATCH);
    dir_d    = wdata;
    latch_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

  always_comb begin
    unique case (sel)
      ADDR_PINS:  rdata = pin_q;
      ADDR_DIR:   rdata = dir_q;
      ADDR_LATCH: rdata = latch_q;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH    = 6,
  parameter int SCK_BIT  = 5,
  parameter int MISO_BIT = 4,
  parameter int MOSI_BIT = 3,
  parameter int SS_BIT   = 2
) (
  input  logic             rst_n,
  input  spi_role_e        role,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] latch,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] out,
  output logic [WIDTH-1:0] pu
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    localparam bit SLAVE_IN  = (i == SCK_BIT) || (i == MOSI_BIT) || (i == SS_BIT);
    localparam bit MASTER_IN = (i == MISO_BIT);

    logic force_in;
    logic drive;

    always_comb begin
      force_in = ((role == ROLE_SLAVE)  && SLAVE_IN) ||
                 ((role == ROLE_MASTER) && MASTER_IN);
      drive    = dir[i] && !force_in && rst_n;
    end

    assign oe[i]  = drive;
    assign out[i] = latch[i];
    assign pu[i]  = latch[i] && !drive;
  end

endmodule

// File: rtl/gpio_spi_port.sv
module gpio_spi_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int SCK_BIT     = 5,
  parameter int MISO_BIT    = 4,
  parameter int MOSI_BIT    = 3,
  parameter int SS_BIT      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_pu,
  output logic             spi_sel
);

  logic             rst_q_n;
  logic [NPINS-1:0] pin_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] latch_q;
  spi_role_e        role;

  always_comb begin
    if (!spi_en) begin
      role = ROLE_OFF;
    end else if (spi_master) begin
      role = ROLE_MASTER;
    end else begin
      role = ROLE_SLAVE;
    end
  end

  gpio_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_q_n (rst_q_n)
  );

  gpio_in_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     (pin_in),
    .q     (pin_q)
  );

  gpio_regs #(
    .WIDTH (NPINS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .pin_q   (pin_q),
    .dir_q   (dir_q),
    .latch_q (latch_q),
    .rdata   (bus_rdata)
  );

  gpio_pin_mux #(
    .WIDTH    (NPINS),
    .SCK_BIT  (SCK_BIT),
    .MISO_BIT (MISO_BIT),
    .MOSI_BIT (MOSI_BIT),
    .SS_BIT   (SS_BIT)
  ) u_mux (
    .rst_n (rst_n),
    .role  (role),
    .dir   (dir_q),
    .latch (latch_q),
    .oe    (pad_oe),
    .out   (pad_out),
    .pu    (pad_pu)
  );

  assign spi_sel = (role == ROLE_SLAVE) && !pin_q[SS_BIT];

endmodule

// File: rtl/gpio_spi_port_chk.sv
module gpio_spi_port_chk #(
  parameter int NPINS       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int SCK_BIT     = 5,
  parameter int MISO_BIT    = 4,
  parameter int MOSI_BIT    = 3,
  parameter int SS_BIT      = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_q_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] bus_rdata,
  input logic             spi_en,
  input logic             spi_master,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pu,
  input logic             spi_sel
);

  logic [1:0] warm_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      warm_q <= 2'd0;
    end else if (warm_q != 2'd2) begin
      warm_q <= warm_q + 2'd1;
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_tristate_r12: assert (pad_oe == '0);
    end
  end

  p_out_no_pullup_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pad_oe & pad_pu) == '0);

  p_slave_force_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (spi_en && !spi_master) |->
      (!pad_oe[SCK_BIT] && !pad_oe[MOSI_BIT] && !pad_oe[SS_BIT]));

  p_master_force_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (spi_en && spi_master) |-> !pad_oe[MISO_BIT]);

  p_low_pins_dir_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && bus_addr == 2'd1) |=> (pad_oe[1:0] == $past(bus_wdata[1:0])));

  p_sel_role_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    spi_sel |-> (spi_en && !spi_master));

  if (SYNC_STAGES == 2) begin : g_lat
    p_pin_latency_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
      (warm_q == 2'd2 && bus_addr == 2'd0) |-> (bus_rdata == $past(pin_in, 2)));
  end

endmodule

bind gpio_spi_port gpio_spi_port_chk #(
  .NPINS       (NPINS),
  .SYNC_STAGES (SYNC_STAGES),
  .SCK_BIT     (SCK_BIT),
  .MISO_BIT    (MISO_BIT),
  .MOSI_BIT    (MOSI_BIT),
  .SS_BIT      (SS_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_q_n    (rst_q_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .spi_en     (spi_en),
  .spi_master (spi_master),
  .pin_in     (pin_in),
  .pad_oe     (pad_oe),
  .pad_pu     (pad_pu),
  .spi_sel    (spi_sel)
);

// File: tb/tb_gpio_spi_port.sv
module tb_gpio_spi_port;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [5:0] bus_wdata;
  logic [5:0] bus_rdata;
  logic       spi_en;
  logic       spi_master;
  logic [5:0] pin_in;
  logic [5:0] pad_oe;
  logic [5:0] pad_out;
  logic [5:0] pad_pu;
  logic       spi_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  gpio_spi_port dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .spi_en     (spi_en),
    .spi_master (spi_master),
    .pin_in     (pin_in),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pu     (pad_pu),
    .spi_sel    (spi_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [5:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [5:0] force_mask(input int mode);
    if (mode == 1) return 6'b101100;
    if (mode == 2) return 6'b010000;
    return 6'b000000;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [5:0] rd;
    logic [5:0] prev;
    logic [5:0] exp_oe;
    logic [5:0] fm;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    spi_en = 1'b0; spi_master = 1'b0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_reg(2'd1, rd); chk("R1 dir", rd, 0);
    rd_reg(2'd2, rd); chk("R1 latch", rd, 0);
    chk("R1 oe", pad_oe, 0);
    chk("R1 pu", pad_pu, 0);

    // R2..R4, R7..R10 exhaustive sweep
    for (int d = 0; d < 64; d++) begin
      wr_reg(2'd1, 6'(d));
      rd_reg(2'd1, rd); chk("R5 dir readback", rd, d);
      for (int l = 0; l < 64; l++) begin
        wr_reg(2'd2, 6'(l));
        for (int m = 0; m < 3; m++) begin
          spi_en = (m != 0); spi_master = (m == 2);
          #1;
          fm = force_mask(m);
          exp_oe = 6'(d) & ~fm;
          chk(m == 1 ? "R7 slave oe" : (m == 2 ? "R8 master oe" : "R2 oe"), pad_oe, exp_oe);
          chk("R3 out", pad_out, l);
          chk(fm != 0 ? "R9 pu" : "R4 pu", pad_pu, 6'(l) & ~exp_oe);
          chk("R10 low pins", {pad_oe[1:0], pad_pu[1:0]},
              {2'(d), 2'(l) & ~2'(d)});
        end
        spi_en = 1'b0; spi_master = 1'b0;
      end
    end

    // R5 ignored writes and unused address
    wr_reg(2'd1, 6'h15);
    wr_reg(2'd2, 6'h2A);
    wr_reg(2'd0, 6'h3F);
    wr_reg(2'd3, 6'h3F);
    rd_reg(2'd1, rd); chk("R5 dir unchanged", rd, 6'h15);
    rd_reg(2'd2, rd); chk("R5 latch unchanged", rd, 6'h2A);
    rd_reg(2'd3, rd); chk("R5 addr3 zero", rd, 0);
    chk("R5 oe unchanged", pad_oe, 6'h15);

    // R6 two-edge latency
    bus_addr = 2'd0;
    prev = 6'h00;
    pin_in = prev;
    repeat (3) @(negedge clk);
    for (int v = 1; v < 64; v++) begin
      pin_in = 6'(v);
      @(negedge clk);
      chk("R6 one edge old", bus_rdata, prev);
      @(negedge clk);
      chk("R6 two edges new", bus_rdata, v);
      prev = 6'(v);
    end

    // R11 select
    spi_en = 1'b1; spi_master = 1'b0;
    pin_in = 6'b000000;
    repeat (2) @(negedge clk);
    chk("R11 sel low", spi_sel, 1);
    pin_in = 6'b000100;
    repeat (2) @(negedge clk);
    chk("R11 sel high", spi_sel, 0);
    pin_in = 6'b000000;
    spi_master = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 master no sel", spi_sel, 0);
    spi_en = 1'b0;
    #1;
    chk("R11 off no sel", spi_sel, 0);

    // R12 async reset mid-cycle
    wr_reg(2'd1, 6'h3F);
    chk("R12 pre oe", pad_oe, 6'h3F);
    @(posedge clk);
    #5;
    rst_n = 1'b0;
    #1;
    chk("R12 oe async", pad_oe, 0);
    chk("R12 pu async", pad_pu, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_reg(2'd1, rd); chk("R1 dir after reset", rd, 0);

    finish_run();
  end

endmodule